// File: doc/BRIEF.md
# Pointer-Addressed Two-Wire Register Slave with Packet Error Check

This block is a target device on a two-wire SMBus/I2C-style bus. It samples the clock and data lines with the system clock and pulls the data line low through an open-drain enable. It answers one fixed 7-bit device address. Behind that address sits a small register file, reached through an 8-bit address pointer.

A write transaction always loads the pointer from its first data byte. An optional second byte is stored into the register that the pointer selects. A read transaction carries no pointer byte and returns the register at the current pointer.

If the master clocks one extra byte, a CRC-8 packet error code covers the whole transaction. On a read the block sends that code; on a write it checks it. The block also has two independently enabled bus-stall timeouts. Each one returns the block to idle when its line stays low too long.

Top module: `smb_reg_slave`

## Requirements
- R1: The device answers the 7-bit address 0x4C, or 0x4B when the alternate-address parameter is set. The address travels MSB first and is followed by a direction bit (0 = write, 1 = read), so the address byte is 0x98 for a write and 0x99 for a read. An address byte for any other device is not acknowledged.
- R2: A start is a falling data line while the clock is high, and a stop is a rising data line while the clock is high. After a stop the block is idle and releases the data line.
- R3: Every accepted byte is acknowledged by holding the data line low through the whole high phase of the ninth clock. The data line is only changed by the block while the clock is low.
- R4: The first data byte of a write is loaded into the pointer. A write that carries only that byte changes no register.
- R5: A second write byte is stored into the register that the pointer selects. The store takes effect at the following stop or repeated start.
- R6: A read returns the register at the current pointer. Repeated reads with no pointer write return the same register. A master not-acknowledge ends the read.
- R7: Read and write decode are separate:
  - Pointer values 0x10-0x2F are read and written at the same address.
  - Writes to 0x30-0x3F land in the registers that are read at 0x00-0x0F.
  - Writes to 0x00-0x0F and to 0x40 and above are ignored.
  - Reads at 0x30-0x3F return the identity byte 0x81, and reads at 0x40 and above return 0x00.
  - All registers reset to 0x00.
- R8: If the master acknowledges the read data byte, the next byte sent is the CRC-8 (polynomial x^8+x^2+x+1, initial value 0x00, MSB first) of every byte of the transaction, address bytes included.
- R9: A third write byte is compared with the CRC-8 of the preceding bytes. On a match it is acknowledged and the store proceeds. On a mismatch it is not acknowledged and the pending store is discarded.
- R10: The CRC starts from 0x00 at a start that follows idle and continues across a repeated start. A repeated start restarts byte framing and keeps the pointer.
- R11: Bit 7 of register 0x22 enables the clock-low timeout and bit 6 enables the data-low timeout; both are 0 after reset. When the enabled line stays low for the timeout period, the block goes idle, releases the data line and drops any pending store. With both bits 0, a stalled bus is held indefinitely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
The assertions take for granted that each clock-low phase outlasts the three-cycle input synchronizer. They also take for granted that the master changes the data line only while the clock is low, except when it makes a start or a stop.

The bench master keeps every half period at ten system cycles. It moves the data line a quarter period after each falling clock edge, and it raises or drops the line with the clock held high only inside its start and stop tasks. The timeout cases stall the bus with the clock held low, so no spurious start or stop can appear.

// File: rtl/smb_pkg.sv
// Shared types and the CRC-8 step used by the bus slave.
// Assumes an 8-bit byte and MSB-first processing.
package smb_pkg;
    localparam int BYTE_W = 8;
    localparam logic [7:0] CRC_POLY = 8'h07;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_RACK,
        ST_WAIT
    } bus_st_t;

    // Fold one byte into the running CRC-8, MSB first.
    function automatic logic [7:0] crc8_step(input logic [7:0] crc_in, input logic [7:0] din);
        logic [7:0] c;
        c = crc_in ^ din;
        for (int i = 0; i < BYTE_W; i++) begin
            c = c[7] ? ((c << 1) ^ CRC_POLY) : (c << 1);
        end
        return c;
    endfunction
endpackage

// File: rtl/smb_line_sync.sv
// Synchronizes the bus lines into the clock domain and flags their edges.
// Assumes the lines idle high; reset preloads ones so no false edge appears.
module smb_line_sync #(
    parameter int LINES = 2,
    parameter int DEPTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw,
    output logic [LINES-1:0] lvl,
    output logic [LINES-1:0] rise,
    output logic [LINES-1:0] fall
);
    generate
        for (genvar g = 0; g < LINES; g++) begin : g_line
            logic [DEPTH-1:0] sh;
            // Shift the raw level through the synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n) sh <= '1;
                else        sh <= {sh[DEPTH-2:0], raw[g]};
            end
            assign lvl[g]  = sh[DEPTH-2];
            assign rise[g] = sh[DEPTH-2] & ~sh[DEPTH-1];
            assign fall[g] = ~sh[DEPTH-2] & sh[DEPTH-1];
        end
    endgenerate
endmodule

// File: rtl/smb_timeout.sv
// Counts how long each enabled bus line stays low and pulses on expiry.
// Assumes LIMIT >= 2; index 1 is the clock line, index 0 the data line.
module smb_timeout #(
    parameter int LIMIT = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] line_low,
    input  logic [1:0] en,
    output logic       hit
);
    localparam int CW = $clog2(LIMIT + 1);
    logic [1:0] hit_v;

    generate
        for (genvar g = 0; g < 2; g++) begin : g_cnt
            logic [CW-1:0] cnt;
            // Run while the line is low and enabled, restart otherwise.
            always_ff @(posedge clk) begin
                if (!rst_n || !en[g] || !line_low[g] || hit_v[g]) cnt <= '0;
                else                                               cnt <= cnt + 1'b1;
            end
            assign hit_v[g] = en[g] && line_low[g] && (cnt == CW'(LIMIT - 1));
        end
    endgenerate

    assign hit = |hit_v;
endmodule

// File: rtl/smb_regfile.sv
// Byte register file with separate read and write decode.
// Shared window is read and written in place; an alias window writes the
// read-only low window; the upper read window returns an identity byte.
module smb_regfile #(
    parameter logic [7:0] SHARED_LO = 8'h10,
    parameter logic [7:0] ALIAS_LO  = 8'h30,
    parameter logic [7:0] TOP_END   = 8'h40,
    parameter logic [7:0] CFG_ADDR  = 8'h22,
    parameter logic [7:0] ID_CODE   = 8'h81
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [7:0] waddr,
    input  logic [7:0] wdata,
    input  logic [7:0] raddr,
    output logic [7:0] rdata,
    output logic [1:0] tout_en
);
    localparam int SLOTS = int'(ALIAS_LO);
    localparam int AW    = $clog2(SLOTS);

    logic [7:0]    mem [SLOTS];
    logic          w_hit;
    logic [AW-1:0] w_idx;

    // Map a write address onto a storage slot, or reject it.
    always_comb begin
        w_hit = 1'b0;
        w_idx = '0;
        if (waddr >= SHARED_LO && waddr < ALIAS_LO) begin
            w_hit = 1'b1;
            w_idx = AW'(waddr);
        end else if (waddr >= ALIAS_LO && waddr < TOP_END) begin
            w_hit = 1'b1;
            w_idx = AW'(waddr - ALIAS_LO);
        end
    end

    generate
        for (genvar s = 0; s < SLOTS; s++) begin : g_slot
            // Store the byte when the decoded slot matches.
            always_ff @(posedge clk) begin
                if (!rst_n)                          mem[s] <= '0;
                else if (we && w_hit && w_idx == AW'(s)) mem[s] <= wdata;
            end
        end
    endgenerate

    // Read decode: storage, identity window, or zero.
    always_comb begin
        if (raddr < ALIAS_LO)     rdata = mem[AW'(raddr)];
        else if (raddr < TOP_END) rdata = ID_CODE;
        else                      rdata = 8'h00;
    end

    assign tout_en = {mem[AW'(CFG_ADDR)][7], mem[AW'(CFG_ADDR)][6]};
endmodule

// File: rtl/smb_reg_slave.sv
// Two-wire bus target with an address pointer, CRC-8 packet error code and
// stall timeouts. Assumes the bus is slow against clk (each clock phase lasts
// several clk cycles) and that the master never stretches or arbitrates.
module smb_reg_slave #(
    parameter int         CLK_HZ       = 50_000_000,
    parameter int         TIMEOUT_US   = 25_000,
    parameter bit         USE_ALT_ADDR = 1'b0,
    parameter logic [7:0] ID_CODE      = 8'h81
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe
);
    import smb_pkg::*;

    localparam logic [6:0] DEV_ADDR    = USE_ALT_ADDR ? 7'h4B : 7'h4C;
    localparam int         TOUT_CYCLES = (CLK_HZ / 1_000_000) * TIMEOUT_US;

    logic [1:0] lvl, rise, fall;
    logic       scl_lvl, sda_lvl, scl_rise, scl_fall;
    logic       start_det, stop_det, tout_hit, wr_en, st_idle;
    logic [1:0] tout_en;
    logic [7:0] rd_data;

    bus_st_t    st;
    logic [3:0] bitcnt;
    logic [7:0] shreg, txsh, crc, ptr, pend_d;
    logic [2:0] byte_idx;
    logic [1:0] tx_cnt;
    logic       rw, pend_v, mack, oe_q;

    smb_line_sync #(.LINES(2), .DEPTH(3)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw({scl_i, sda_i}),
        .lvl(lvl), .rise(rise), .fall(fall)
    );

    assign scl_lvl   = lvl[1];
    assign sda_lvl   = lvl[0];
    assign scl_rise  = rise[1];
    assign scl_fall  = fall[1];
    assign start_det = scl_lvl & fall[0];
    assign stop_det  = scl_lvl & rise[0];
    assign st_idle   = (st == ST_IDLE);
    assign wr_en     = pend_v & (stop_det | start_det) & ~tout_hit;

    smb_timeout #(.LIMIT(TOUT_CYCLES)) u_tout (
        .clk(clk), .rst_n(rst_n), .line_low({~scl_lvl, ~sda_lvl}),
        .en(tout_en), .hit(tout_hit)
    );

    smb_regfile #(.ID_CODE(ID_CODE)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(wr_en), .waddr(ptr), .wdata(pend_d),
        .raddr(ptr), .rdata(rd_data), .tout_en(tout_en)
    );

    // Protocol engine: framing, acknowledge, pointer, PEC and transmit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE; bitcnt <= '0; shreg <= '0; txsh <= '0;
            crc <= '0; ptr <= '0; pend_d <= '0; byte_idx <= '0;
            tx_cnt <= '0; rw <= 1'b0; pend_v <= 1'b0; mack <= 1'b0; oe_q <= 1'b0;
        end else if (tout_hit || stop_det) begin
            st <= ST_IDLE; oe_q <= 1'b0; pend_v <= 1'b0;
        end else if (start_det) begin
            if (st == ST_IDLE) crc <= '0;
            st <= ST_RX; bitcnt <= '0; byte_idx <= '0;
            oe_q <= 1'b0; pend_v <= 1'b0;
        end else begin
            case (st)
                ST_RX: begin
                    if (scl_rise) begin
                        shreg  <= {shreg[6:0], sda_lvl};
                        bitcnt <= bitcnt + 1'b1;
                    end else if (scl_fall && bitcnt == 4'd8) begin
                        bitcnt <= '0;
                        if (byte_idx != 3'd7) byte_idx <= byte_idx + 1'b1;
                        st   <= ST_ACK;
                        oe_q <= 1'b1;
                        if (byte_idx == 3'd0) begin
                            if (shreg[7:1] == DEV_ADDR) begin
                                rw  <= shreg[0];
                                crc <= crc8_step(crc, shreg);
                            end else begin
                                st <= ST_WAIT; oe_q <= 1'b0;
                            end
                        end else if (byte_idx == 3'd1) begin
                            ptr <= shreg;
                            crc <= crc8_step(crc, shreg);
                        end else if (byte_idx == 3'd2) begin
                            pend_d <= shreg;
                            pend_v <= 1'b1;
                            crc    <= crc8_step(crc, shreg);
                        end else if (!(byte_idx == 3'd3 && pend_v && shreg == crc)) begin
                            pend_v <= 1'b0;
                            st     <= ST_WAIT;
                            oe_q   <= 1'b0;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        bitcnt <= '0;
                        if (rw) begin
                            txsh   <= rd_data;
                            crc    <= crc8_step(crc, rd_data);
                            tx_cnt <= 2'd1;
                            oe_q   <= ~rd_data[7];
                            st     <= ST_TX;
                        end else begin
                            oe_q <= 1'b0;
                            st   <= ST_RX;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (bitcnt == 4'd7) begin
                            oe_q <= 1'b0;
                            st   <= ST_RACK;
                        end else begin
                            txsh   <= {txsh[6:0], 1'b0};
                            oe_q   <= ~txsh[6];
                            bitcnt <= bitcnt + 1'b1;
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        mack <= ~sda_lvl;
                    end else if (scl_fall) begin
                        if (mack) begin
                            txsh   <= (tx_cnt == 2'd1) ? crc : 8'hFF;
                            oe_q   <= (tx_cnt == 2'd1) ? ~crc[7] : 1'b0;
                            tx_cnt <= 2'd2;
                            bitcnt <= '0;
                            st     <= ST_TX;
                        end else begin
                            st <= ST_WAIT;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign sda_oe = oe_q;
endmodule

// File: rtl/smb_reg_slave_chk.sv
// Property checker for smb_reg_slave, attached by bind.
// Assumes clock-low phases longer than the input synchronizer delay.
module smb_reg_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_i,
    input logic sda_oe,
    input logic st_idle,
    input logic start_det,
    input logic stop_det,
    input logic wr_en,
    input logic tout_hit
);
    // R2: an idle block never pulls the data line.
    p_idle_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_idle |-> !sda_oe);

    // R2: a stop always returns the block to idle.
    p_stop_idles_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> st_idle);

    // R3: the data drive only changes while the bus clock is low.
    p_drive_on_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_i);

    // R5: a register store happens only on a stop or a repeated start.
    p_commit_at_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (stop_det || start_det));

    // R11: an expired timeout leaves the block idle with the line released.
    p_tout_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
        tout_hit |=> (st_idle && !sda_oe));
endmodule

bind smb_reg_slave smb_reg_slave_chk chk_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
    .st_idle(st_idle), .start_det(start_det), .stop_det(stop_det),
    .wr_en(wr_en), .tout_hit(tout_hit)
);

// File: tb/smb_reg_slave_tb_top.sv
// Bench: a bit-banged master drives the slave; expectations come from a
// behavioural register model and a bench CRC function.
module smb_reg_slave_tb_top;
    localparam int Q = 5;
    localparam int TOUT = 500;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic sda_line;
    int   n_chk = 0;
    int   n_fail = 0;
    logic [7:0] slot [48];

    always #10 clk = ~clk;
    assign sda_line = sda_m & ~sda_oe;

    smb_reg_slave #(.TIMEOUT_US(10)) dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe)
    );

    function automatic logic [7:0] ref_crc(input logic [7:0] c, input logic [7:0] b);
        logic [7:0] r;
        r = c ^ b;
        for (int i = 0; i < 8; i++) r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
        return r;
    endfunction

    function automatic logic [7:0] mdl_read(input logic [7:0] p);
        if (p < 8'h30) return slot[p[5:0]];
        if (p < 8'h40) return 8'h81;
        return 8'h00;
    endfunction

    task automatic mdl_write(input logic [7:0] p, input logic [7:0] d);
        if (p >= 8'h10 && p < 8'h30) slot[p[5:0]] = d;
        else if (p >= 8'h30 && p < 8'h40) slot[p[5:0] - 6'h30] = d;
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic m_start();
        sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(2*Q);
        sda_m = 1'b0; wq(2*Q); scl_m = 1'b0;
    endtask

    task automatic m_stop();
        wq(Q); sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(2*Q);
        sda_m = 1'b1; wq(2*Q);
    endtask

    task automatic m_wbyte(input logic [7:0] b, output logic ack);
        logic a1;
        for (int i = 7; i >= 0; i--) begin
            wq(Q); sda_m = b[i]; wq(Q); scl_m = 1'b1; wq(2*Q); scl_m = 1'b0;
        end
        wq(Q); sda_m = 1'b1; wq(Q); scl_m = 1'b1;
        wq(1); a1 = ~sda_line;
        wq(2*Q - 2); ack = a1 & ~sda_line;
        wq(1); scl_m = 1'b0;
    endtask

    task automatic m_rbyte(input logic give_ack, output logic [7:0] d);
        for (int i = 7; i >= 0; i--) begin
            wq(Q); sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q);
            d[i] = sda_line; wq(Q); scl_m = 1'b0;
        end
        wq(Q); sda_m = ~give_ack; wq(Q); scl_m = 1'b1; wq(2*Q); scl_m = 1'b0;
        wq(Q); sda_m = 1'b1;
    endtask

    // Write transaction; acks packs the acknowledge of each byte sent.
    task automatic wr_reg(input logic [7:0] p, input logic [7:0] d, input bit use_pec,
                          input bit bad_pec, output logic [3:0] acks);
        logic a;
        logic [7:0] c;
        acks = '0;
        c = ref_crc(ref_crc(ref_crc(8'h00, 8'h98), p), d);
        m_start();
        m_wbyte(8'h98, a); acks[0] = a;
        m_wbyte(p, a);     acks[1] = a;
        m_wbyte(d, a);     acks[2] = a;
        if (use_pec) begin
            m_wbyte(bad_pec ? ~c : c, a); acks[3] = a;
        end
        m_stop();
    endtask

    task automatic set_ptr(input logic [7:0] p);
        logic a;
        m_start(); m_wbyte(8'h98, a); m_wbyte(p, a); m_stop();
    endtask

    task automatic rd_cur(output logic [7:0] d);
        logic a;
        m_start(); m_wbyte(8'h99, a); m_rbyte(1'b0, d); m_stop();
    endtask

    // Stall the bus with the clock low right after a read address is acked.
    task automatic stall_read(input int hold, output logic drv_before, output logic drv_after);
        logic a;
        m_start(); m_wbyte(8'h99, a);
        wq(20); drv_before = sda_oe;
        wq(hold); drv_after = sda_oe;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [3:0] acks;
        logic [7:0] d, pec;
        logic a, b0, b1;
        void'($urandom(32'd4242));
        for (int i = 0; i < 48; i++) slot[i] = 8'h00;
        wq(5); rst_n = 1'b1; wq(5);

        chk("R2 reset release", {7'd0, sda_oe}, 8'h00);

        // R1: foreign address is ignored, own read address acknowledged.
        m_start(); m_wbyte(8'h96, a); m_stop();
        chk("R1 foreign address nack", {7'd0, a}, 8'h00);
        m_start(); m_wbyte(8'h99, a); m_rbyte(1'b0, d); m_stop();
        chk("R1 own address ack", {7'd0, a}, 8'h01);
        chk("R2 idle after stop", {7'd0, sda_oe}, 8'h00);

        // R3/R5: directed write of a shared register, every byte acked.
        wr_reg(8'h15, 8'h3C, 1'b0, 1'b0, acks); mdl_write(8'h15, 8'h3C);
        chk("R3 acks on write", {5'd0, acks[2:0]}, 8'h07);
        // R4: pointer-only write must not disturb the register.
        set_ptr(8'h15); rd_cur(d);
        chk("R5 stored byte", d, 8'h3C);
        chk("R4 pointer-only write leaves data", d, mdl_read(8'h15));
        rd_cur(d);
        chk("R6 reread keeps pointer", d, 8'h3C);

        // R7: read-only low window, alias writes, identity window.
        wr_reg(8'h03, 8'hEE, 1'b0, 1'b0, acks);
        set_ptr(8'h03); rd_cur(d);
        chk("R7 write to read-only ignored", d, 8'h00);
        wr_reg(8'h33, 8'h6B, 1'b0, 1'b0, acks); mdl_write(8'h33, 8'h6B);
        set_ptr(8'h03); rd_cur(d);
        chk("R7 alias write lands at read address", d, 8'h6B);
        set_ptr(8'h3D); rd_cur(d);
        chk("R7 identity byte", d, 8'h81);
        set_ptr(8'h55); rd_cur(d);
        chk("R7 unmapped read", d, 8'h00);

        // R7 random sweep with optional PEC bytes.
        for (int k = 0; k < 24; k++) begin
            logic [7:0] p, v;
            bit use_pec;
            p = 8'($urandom_range(0, 79));
            v = 8'($urandom_range(0, 255));
            use_pec = bit'($urandom_range(0, 1));
            if (p == 8'h22) v = v & 8'h3F;
            wr_reg(p, v, use_pec, 1'b0, acks);
            mdl_write(p, v);
            set_ptr(p); rd_cur(d);
            chk("R7 random write/read", d, mdl_read(p));
        end

        // R9: good PEC accepted, bad PEC rejected and store dropped.
        wr_reg(8'h19, 8'h77, 1'b1, 1'b0, acks); mdl_write(8'h19, 8'h77);
        chk("R9 good pec acked", {7'd0, acks[3]}, 8'h01);
        wr_reg(8'h19, 8'h11, 1'b1, 1'b1, acks);
        chk("R9 bad pec nacked", {7'd0, acks[3]}, 8'h00);
        set_ptr(8'h19); rd_cur(d);
        chk("R9 bad pec store discarded", d, 8'h77);

        // R8: PEC byte on a plain read.
        set_ptr(8'h15);
        m_start(); m_wbyte(8'h99, a); m_rbyte(1'b1, d); m_rbyte(1'b0, pec); m_stop();
        chk("R8 read data", d, mdl_read(8'h15));
        chk("R8 read pec", pec, ref_crc(ref_crc(8'h00, 8'h99), d));

        // R10: combined transaction through a repeated start.
        wr_reg(8'h18, 8'h5A, 1'b0, 1'b0, acks); mdl_write(8'h18, 8'h5A);
        m_start(); m_wbyte(8'h98, a); m_wbyte(8'h18, a);
        m_start(); m_wbyte(8'h99, a); m_rbyte(1'b1, d); m_rbyte(1'b0, pec); m_stop();
        chk("R10 data after repeated start", d, 8'h5A);
        chk("R10 pec spans repeated start", pec,
            ref_crc(ref_crc(ref_crc(ref_crc(8'h00, 8'h98), 8'h18), 8'h99), 8'h5A));
        rd_cur(d);
        chk("R10 pointer kept", d, 8'h5A);

        // R11: clock-low timeout enabled.
        wr_reg(8'h20, 8'h00, 1'b0, 1'b0, acks); mdl_write(8'h20, 8'h00);
        wr_reg(8'h22, 8'h80, 1'b0, 1'b0, acks);
        set_ptr(8'h20);
        stall_read(TOUT + 100, b0, b1);
        chk("R11 driving before stall", {7'd0, b0}, 8'h01);
        chk("R11 scl timeout releases", {7'd0, b1}, 8'h00);
        m_stop();

        // R11: timeouts disabled, stall is held.
        wr_reg(8'h22, 8'h00, 1'b0, 1'b0, acks);
        set_ptr(8'h20);
        stall_read(2*TOUT + 200, b0, b1);
        chk("R11 disabled keeps driving", {7'd0, b1}, 8'h01);
        m_rbyte(1'b0, d); m_stop();
        chk("R11 read completes after stall", d, 8'h00);

        // R11: data-low timeout enabled.
        wr_reg(8'h22, 8'h40, 1'b0, 1'b0, acks);
        set_ptr(8'h20);
        stall_read(TOUT + 100, b0, b1);
        chk("R11 sda timeout releases", {7'd0, b1}, 8'h00);
        m_stop();
        wr_reg(8'h22, 8'h00, 1'b0, 1'b0, acks);
        set_ptr(8'h22); rd_cur(d);
        chk("R11 config readback", d, 8'h00);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule